// File: doc/BRIEF.md
# Chained-Rotation Output Permuter

This block is the output stage of a pseudorandom generator with a 128-bit state. It takes any 128-bit state word and returns a 128-bit output word. It first XORs the two state halves together and rotates the result right by the six most significant state bits. It then rotates the upper state half right by the low six bits of that first result. The second rotation therefore depends on the first one. Every step can be undone, so each output word corresponds to exactly one state word and the distribution of the generator feeding the block is preserved. The block does not update the generator state.

Words enter and leave through valid/ready handshakes. The work is split into two register stages, one rotation per stage. When the consumer stops taking words, the whole pipeline freezes: the word on the output is held and the input stops accepting. No word is lost or duplicated. The half width is a parameter, and the rotate-amount width is derived from it.

Top module: `state_mix_permuter`

## Requirements
- R1: While reset is asserted (active-low `rstN`) and right after it is released, `outValid` is 0 and `inReady` is 1.
- R2: Output bits [63:0] equal (state[63:0] XOR state[127:64]) rotated right by the amount held in state[127:122].
- R3: Output bits [127:64] equal state[127:64] rotated right by the amount held in output bits [5:0].
- R4: A rotate amount of zero leaves a word unchanged in both rotations. A state with state[127:122] = 0 whose XOR fold has bits [5:0] = 0 yields {state[127:64], fold}.
- R5: A word accepted at clock edge n, with the pipeline empty and `outReady` high, shows up on `outValid`/`outData` after edge n+1. With `outReady` held high, one word is accepted on every cycle.
- R6: While `outValid` is 1 and `outReady` is 0, `outValid` and `outData` hold their values and `inReady` is 0.
- R7: Every accepted word is delivered exactly once, in the order it was accepted, under any pattern of backpressure.
- R8: The mapping can be inverted. The state is {H, (rotl(L, H[63:58])) XOR H}, where L = output[63:0] and H = rotl(output[127:64], L[5:0]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A state word is offered |
| inReady | output | 1 | The block takes the offered word at this edge |
| inState | input | 128 | Generator state word |
| outValid | output | 1 | An output word is present |
| outReady | input | 1 | The consumer takes the output word at this edge |
| outData | output | 128 | Permuted output word |

## Verification
A word accepted at edge n becomes visible after edge n+1. The latency scenario therefore samples just before edge n+1, where `outValid` must still be low, and again before edge n+2, where the word must be present. All handshake signals are sampled two nanoseconds before a rising edge, so a sampled accept or transfer is exactly the one that the next edge carries out. A queue records the accepted states in that order. Each transfer pops the queue and is compared against a reference model and against the inverse mapping. During a stall, the held word is compared on every sampled cycle until the stall is released.

// File: rtl/mixperm_pkg.sv
package mixperm_pkg;

  // Load strobes from control to datapath
  typedef struct packed {
    logic loadFront;  // capture first-rotation result and upper state half
    logic loadBack;   // capture final output word
  } mixStrobe_t;

endpackage

// File: rtl/mixperm_rotr.sv
module mixperm_rotr #(
  parameter int WIDTH = 64,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  output logic [WIDTH-1:0] dout
);

  // Logarithmic rotator: stage g rotates right by 2**g when amt[g] is set
  logic [WIDTH-1:0] stageVal [0:AMT_W];

  assign stageVal[0] = din;

  for (genvar g = 0; g < AMT_W; g++) begin : g_stage
    localparam int SH = 1 << g;
    assign stageVal[g+1] = amt[g]
      ? {stageVal[g][SH-1:0], stageVal[g][WIDTH-1:SH]}
      : stageVal[g];
  end

  assign dout = stageVal[AMT_W];

  always_comb begin
    if (!$isunknown({din, amt}) && amt == '0) begin
      assert_zero_amt_R4 : assert (dout == din);
    end
  end

endmodule

// File: rtl/mixperm_ctrl.sv
module mixperm_ctrl
  import mixperm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output mixStrobe_t strobe
);

  logic frontValid;
  logic backValid;
  logic advance;

  // Whole pipeline moves together unless a held output is refused
  assign advance = !backValid || outReady;

  assign inReady          = advance;
  assign outValid         = backValid;
  assign strobe.loadFront = advance;
  assign strobe.loadBack  = advance;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frontValid <= 1'b0;
      backValid  <= 1'b0;
    end else if (advance) begin
      frontValid <= inValid;
      backValid  <= frontValid;
    end
  end

  assert_accept_fills_R5 : assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> frontValid);

  assert_front_drains_R5 : assert property (@(posedge clk) disable iff (!rstN)
    frontValid && inReady |=> outValid);

  assert_stall_keep_R6 : assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  assert_stall_block_R6 : assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

endmodule

// File: rtl/mixperm_datapath.sv
module mixperm_datapath
  import mixperm_pkg::*;
#(
  parameter int HALF_W = 64,
  localparam int STATE_W = 2 * HALF_W,
  localparam int AMT_W = $clog2(HALF_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  mixStrobe_t         strobe,
  input  logic [STATE_W-1:0] inState,
  output logic [STATE_W-1:0] outData
);

  logic [HALF_W-1:0] foldWord;
  logic [AMT_W-1:0]  firstAmt;
  logic [HALF_W-1:0] lowRot;
  logic [HALF_W-1:0] lowReg;
  logic [HALF_W-1:0] highReg;
  logic [HALF_W-1:0] highRot;

  // Front stage: fold halves, rotate by top state bits
  assign foldWord = inState[HALF_W-1:0] ^ inState[STATE_W-1:HALF_W];
  assign firstAmt = inState[STATE_W-1 -: AMT_W];

  mixperm_rotr #(.WIDTH(HALF_W)) u_rotFront (
    .din (foldWord),
    .amt (firstAmt),
    .dout(lowRot)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowReg  <= '0;
      highReg <= '0;
    end else if (strobe.loadFront) begin
      lowReg  <= lowRot;
      highReg <= inState[STATE_W-1:HALF_W];
    end
  end

  // Back stage: rotate the upper half by the low bits of the first result
  mixperm_rotr #(.WIDTH(HALF_W)) u_rotBack (
    .din (highReg),
    .amt (lowReg[AMT_W-1:0]),
    .dout(highRot)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData <= '0;
    end else if (strobe.loadBack) begin
      outData <= {highRot, lowReg};
    end
  end

  assert_low_pass_R2 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBack |=> outData[HALF_W-1:0] == $past(lowReg));

endmodule

// File: rtl/state_mix_permuter.sv
module state_mix_permuter
  import mixperm_pkg::*;
#(
  parameter int HALF_W = 64,
  localparam int STATE_W = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [STATE_W-1:0] inState,
  output logic               outValid,
  input  logic               outReady,
  output logic [STATE_W-1:0] outData
);

  mixStrobe_t strobe;

  mixperm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .outValid(outValid),
    .outReady(outReady),
    .strobe  (strobe)
  );

  mixperm_datapath #(.HALF_W(HALF_W)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inState(inState),
    .outData(outData)
  );

  assert_stall_data_R6 : assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData));

endmodule

// File: tb/state_mix_permuter_bench.sv
`timescale 1ns/1ps
module state_mix_permuter_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inState = '0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [127:0] outData;

  int checks = 0;
  int fails = 0;
  int samples = 0;
  int accepted = 0;
  int delivered = 0;
  logic [127:0] expQ[$];
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  state_mix_permuter u_state_mix_permuter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inState(inState), .outValid(outValid), .outReady(outReady),
    .outData(outData)
  );

  function automatic logic [63:0] rotr64(logic [63:0] x, int unsigned r);
    r = r & 63;
    return (r == 0) ? x : ((x >> r) | (x << (64 - r)));
  endfunction

  function automatic logic [63:0] rotl64(logic [63:0] x, int unsigned r);
    r = r & 63;
    return (r == 0) ? x : ((x << r) | (x >> (64 - r)));
  endfunction

  function automatic logic [127:0] model(logic [127:0] s);
    logic [63:0] hi, lo;
    hi = s[127:64];
    lo = rotr64(s[63:0] ^ hi, int'(s[127:122]));
    return {rotr64(hi, int'(lo[5:0])), lo};
  endfunction

  function automatic logic [127:0] invert(logic [127:0] o);
    logic [63:0] lo, hi;
    lo = o[63:0];
    hi = rotl64(o[127:64], int'(lo[5:0]));
    return {hi, rotl64(lo, int'(hi[63:58])) ^ hi};
  endfunction

  function automatic logic [63:0] nextRng(logic [63:0] x);
    x ^= x << 13;
    x ^= x >> 7;
    x ^= x << 17;
    return x;
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Sample point: 2 ns before each rising edge
  always @(negedge clk) begin
    #8;
    samples++;
    if (rstN) begin
      if (inValid && inReady) begin
        expQ.push_back(inState);
        accepted++;
      end
      if (outValid && outReady) begin
        logic [127:0] s;
        delivered++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R7 unexpected word", outData, '0);
        end else begin
          s = expQ.pop_front();
          chk(outData == model(s), "R2 R3 output mapping", outData, model(s));
          chk(invert(outData) == s, "R8 inverse mapping", invert(outData), s);
        end
      end
    end
  end

  task automatic sample_point();
    @(negedge clk);
    #8;
  endtask

  task automatic drive_point();
    @(posedge clk);
    #1;
  endtask

  // Offer one word; returns at posedge+1 after it is taken
  task automatic push(input logic [127:0] s);
    logic acc;
    inValid = 1'b1;
    inState = s;
    do begin
      sample_point();
      acc = inReady;
      drive_point();
    end while (!acc);
  endtask

  task automatic idle_drain(input int n);
    inValid = 1'b0;
    repeat (n) drive_point();
  endtask

  task automatic test_reset();
    rstN = 1'b0;
    repeat (3) drive_point();
    sample_point();
    chk(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    chk(inReady == 1'b1, "R1 inReady in reset", inReady, 1);
    drive_point();
    rstN = 1'b1;
    sample_point();
    chk(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    chk(inReady == 1'b1, "R1 inReady after reset", inReady, 1);
    drive_point();
  endtask

  task automatic test_latency();
    logic [127:0] s = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    outReady = 1'b1;
    push(s);
    inValid = 1'b0;
    sample_point();
    chk(outValid == 1'b0, "R5 not yet valid after edge n", outValid, 0);
    drive_point();
    sample_point();
    chk(outValid == 1'b1, "R5 valid after edge n+1", outValid, 1);
    chk(outData == model(s), "R5 data after edge n+1", outData, model(s));
    drive_point();
    idle_drain(2);
  endtask

  task automatic test_zero_rot();
    logic [127:0] s;
    logic [127:0] exp;
    s = {64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF ^ 64'h0F0F_0000_0000_0040};
    exp = {64'h0123_4567_89AB_CDEF, 64'h0F0F_0000_0000_0040};
    push(s);
    inValid = 1'b0;
    sample_point();
    drive_point();
    sample_point();
    chk(outData == exp, "R4 zero amounts pass through", outData, exp);
    drive_point();
    idle_drain(2);
    // corner amounts: largest first rotation, largest second rotation
    push({64'hFC00_0000_0000_0001, 64'hFC00_0000_0000_0001 ^ 64'h0000_0000_0000_003F});
    push({64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000});
    push('0);
    idle_drain(4);
  endtask

  task automatic test_stream();
    int s0;
    outReady = 1'b1;
    s0 = samples;
    for (int i = 0; i < 20; i++) begin
      rng = nextRng(rng);
      push({rng, ~rng ^ 64'(i)});
    end
    chk(samples - s0 == 20, "R5 one word per cycle", 128'(samples - s0), 128'd20);
    idle_drain(4);
  endtask

  task automatic test_backpressure();
    logic [127:0] a = 128'hAAAA_0000_1111_2222_3333_4444_5555_6666;
    logic [127:0] b = 128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321;
    logic [127:0] c = 128'hDEAD_BEEF_CAFE_F00D_0BAD_F00D_FACE_B00C;
    outReady = 1'b0;
    push(a);
    push(b);
    inValid = 1'b1;
    inState = c;
    for (int k = 0; k < 4; k++) begin
      sample_point();
      chk(inReady == 1'b0, "R6 input blocked while stalled", inReady, 0);
      chk(outValid == 1'b1, "R6 valid held while stalled", outValid, 1);
      chk(outData == model(a), "R6 data held while stalled", outData, model(a));
      drive_point();
    end
    outReady = 1'b1;
    push(c);
    idle_drain(5);
    chk(expQ.size() == 0, "R7 all stalled words delivered", 128'(expQ.size()), 0);
  endtask

  task automatic test_random_stall();
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          rng = nextRng(rng);
          push({rng, nextRng(rng)});
        end
        inValid = 1'b0;
      end
      begin
        for (int k = 0; k < 90; k++) begin
          rng = nextRng(rng);
          outReady = rng[3] | rng[9];
          drive_point();
        end
        outReady = 1'b1;
      end
    join
    idle_drain(6);
    chk(expQ.size() == 0, "R7 queue empty after random stalls", 128'(expQ.size()), 0);
    chk(accepted == delivered, "R7 accepted equals delivered",
        128'(delivered), 128'(accepted));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    test_reset();
    test_latency();
    test_zero_rot();
    test_stream();
    test_backpressure();
    test_random_stall();
    summary();
  end

endmodule